// File: doc/BRIEF.md
# Two-Phase 16-bit Processor Core

A compact 16-bit processor whose controller has only two phases. In the fetch phase the incoming instruction word is latched into the instruction register, and any data-memory access it calls for is set up. In the execute phase the ALU result or the loaded word is written back, the flags are updated and the address of the next instruction is presented. Every instruction therefore takes exactly two clock cycles. The core has sixteen 16-bit registers. It talks to one synchronous memory that holds both instructions and data, through an address port, a write-data port, a write strobe and a read-data port. The memory has one cycle of read latency.

Instruction fields are op = [15:12], rd = [11:8], rs = [7:4], fn = [3:0] and imm8 = [7:0]. Constants are built in two steps: a sign-extended byte load, then an upper-byte move. Control transfer uses a register-indirect jump that writes no return address, and conditional branches relative to the PC. Every source choice in the data path comes from a multiplexer that the controller steers.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high at a rising edge the core returns to the fetch phase with PC = 0, drives `mem_addr` = 0 and keeps `mem_we` low. In the first cycle after reset the instruction at address 0 is fetched.
- R2: Fetch and execute alternate strictly, so every instruction takes two cycles. During execute, `mem_addr` carries the next PC. During fetch of a non-memory instruction, `mem_addr` carries the current PC.
- R3: Register ops with op 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR compute rd = rd op rs. op 6 with fn 0 is MOV rd = rs.
- R4: Immediate ops use op 8 ADDI, 9 SUBI, A ANDI, B ORI, C XORI, E MOVI. Each applies the same operation with the sign-extended imm8 in place of rs; MOVI sets rd = sext(imm8).
- R5: op F writes imm8 into rd[15:8] and leaves rd[7:0] as it was.
- R6: op 6 fn 1 sets rd = rs shifted left by one bit. op 6 fn 2 sets rd = rs shifted right by one bit. Both fill the vacated bit with 0.
- R7: ADD, SUB, CMP and their immediate forms set C (carry out, or no borrow for subtraction), Z, N and V. AND, OR, XOR and their immediate forms set Z and N and leave C and V unchanged. CMP (op 5) and CMPI (op D) write no register.
- R8: op 7 is a branch with condition in [11:8] and signed displacement imm8, target = PC + 1 + disp. Conditions: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, A N==V, B N!=V, C !Z&(N==V), D Z|(N!=V), E always, F never.
- R9: op 6 fn 5 jumps to the address held in rs and writes no register, including the one named in its rd field.
- R10: op 6 fn 3 loads rd from memory at address rs. op 6 fn 4 stores rd to address rs. The address and write strobe are driven during fetch, and loaded data is captured at the end of execute.
- R11: The register file is written only in the execute phase, so a value written by one instruction is seen by the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address (instruction or data) |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Read data, one cycle after the address |

## Verification
The hardest cases to reach are flag effects that cross instructions. A branch has to see flags left by one instruction while a later flag-writing instruction has changed only part of them. Likewise, a jump must leave its rd register untouched. The programs reach these cases by placing a compare, then a logic immediate, then back-to-back branches that skip marker moves. Results are reported only through store instructions, so a scoreboard of expected address/data pairs, compared in store order, makes every register value and every branch decision visible at the memory port.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int XLEN = 16;
    localparam int NREG = 16;
    localparam int RIDX = $clog2(NREG);
    localparam int IMMW = 8;

    localparam logic [3:0] OP_MISC = 4'h6;
    localparam logic [3:0] FN_MOV  = 4'h0;
    localparam logic [3:0] FN_SHL  = 4'h1;
    localparam logic [3:0] FN_SHR  = 4'h2;
    localparam logic [3:0] FN_LOAD = 4'h3;
    localparam logic [3:0] FN_STOR = 4'h4;
    localparam logic [3:0] FN_JMP  = 4'h5;

    typedef enum logic [0:0] {PH_FETCH, PH_EXEC} phase_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_PASS, ALU_SHL, ALU_SHR, ALU_UPPER
    } alu_op_e;

    typedef enum logic [1:0] {FL_KEEP, FL_ZN, FL_ALL} flag_mode_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        alu_op_e    alu_op;
        logic       b_imm;
        logic       reg_we;
        logic       wb_mem;
        flag_mode_e flag_mode;
        logic       is_jump;
        logic       is_branch;
    } ctl_t;

    typedef struct packed {
        phase_e            phase;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ir;
        flags_t            flags;
    } core_state_t;

    function automatic logic is_mem_op(input logic [3:0] op, input logic [3:0] fn);
        return (op == OP_MISC) && ((fn == FN_LOAD) || (fn == FN_STOR));
    endfunction

    function automatic logic is_store_op(input logic [3:0] op, input logic [3:0] fn);
        return (op == OP_MISC) && (fn == FN_STOR);
    endfunction

    function automatic logic cond_met(input logic [3:0] cc, input flags_t f);
        logic r;
        case (cc)
            4'h0: r = f.z;
            4'h1: r = !f.z;
            4'h2: r = f.c;
            4'h3: r = !f.c;
            4'h4: r = f.n;
            4'h5: r = !f.n;
            4'h6: r = f.v;
            4'h7: r = !f.v;
            4'h8: r = f.c && !f.z;
            4'h9: r = !f.c || f.z;
            4'hA: r = (f.n == f.v);
            4'hB: r = (f.n != f.v);
            4'hC: r = !f.z && (f.n == f.v);
            4'hD: r = f.z || (f.n != f.v);
            4'hE: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
(
    input  logic [3:0] op,
    input  logic [3:0] fn,
    output ctl_t       ctl
);

    always_comb begin
        ctl        = '0;
        ctl.b_imm  = op[3];
        case (op[2:0])
            3'd0: begin ctl.alu_op = ALU_ADD; ctl.reg_we = 1'b1; ctl.flag_mode = FL_ALL; end
            3'd1: begin ctl.alu_op = ALU_SUB; ctl.reg_we = 1'b1; ctl.flag_mode = FL_ALL; end
            3'd2: begin ctl.alu_op = ALU_AND; ctl.reg_we = 1'b1; ctl.flag_mode = FL_ZN;  end
            3'd3: begin ctl.alu_op = ALU_OR;  ctl.reg_we = 1'b1; ctl.flag_mode = FL_ZN;  end
            3'd4: begin ctl.alu_op = ALU_XOR; ctl.reg_we = 1'b1; ctl.flag_mode = FL_ZN;  end
            3'd5: begin ctl.alu_op = ALU_SUB; ctl.flag_mode = FL_ALL; end
            3'd6: begin
                if (op[3]) begin
                    ctl.alu_op = ALU_PASS;
                    ctl.reg_we = 1'b1;
                end else begin
                    case (fn)
                        FN_MOV:  begin ctl.alu_op = ALU_PASS; ctl.reg_we = 1'b1; end
                        FN_SHL:  begin ctl.alu_op = ALU_SHL;  ctl.reg_we = 1'b1; end
                        FN_SHR:  begin ctl.alu_op = ALU_SHR;  ctl.reg_we = 1'b1; end
                        FN_LOAD: begin ctl.wb_mem = 1'b1;     ctl.reg_we = 1'b1; end
                        FN_JMP:  ctl.is_jump = 1'b1;
                        default: ;
                    endcase
                end
            end
            default: begin
                if (op[3]) begin
                    ctl.alu_op = ALU_UPPER;
                    ctl.reg_we = 1'b1;
                end else begin
                    ctl.is_branch = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         c,
    output logic         v
);

    localparam int HALF = W / 2;

    logic [W:0] sum;
    logic [W:0] diff;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        c    = 1'b0;
        v    = 1'b0;
        case (op)
            ALU_ADD: begin
                y = sum[W-1:0];
                c = sum[W];
                v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                y = diff[W-1:0];
                c = diff[W];
                v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_PASS:  y = b;
            ALU_SHL:   y = {b[W-2:0], 1'b0};
            ALU_SHR:   y = {1'b0, b[W-1:1]};
            ALU_UPPER: y = {b[HALF-1:0], a[HALF-1:0]};
            default:   y = b;
        endcase
    end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] ra,
    input  logic [$clog2(N)-1:0] rb,
    output logic [W-1:0]         rda,
    output logic [W-1:0]         rdb,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    assign rda = regs_q[ra];
    assign rdb = regs_q[rb];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    core_state_t     st_q;
    core_state_t     st_d;
    logic            in_exec;
    ctl_t            ctl_x;
    logic [RIDX-1:0] ra;
    logic [RIDX-1:0] rb;
    logic [XLEN-1:0] rda;
    logic [XLEN-1:0] rdb;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_c;
    logic            alu_v;
    logic            rf_we;
    logic [XLEN-1:0] rf_wd;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] next_pc;
    logic            br_take;

    assign in_exec = (st_q.phase == PH_EXEC);

    // register read addresses: incoming word in fetch, latched word in execute
    assign ra = in_exec ? st_q.ir[11:8] : mem_rdata[11:8];
    assign rb = in_exec ? st_q.ir[7:4]  : mem_rdata[7:4];

    assign imm_sx = {{(XLEN-IMMW){st_q.ir[IMMW-1]}}, st_q.ir[IMMW-1:0]};
    assign alu_b  = ctl_x.b_imm ? imm_sx : rdb;
    assign pc_inc = st_q.pc + XLEN'(1);
    assign br_tgt = pc_inc + imm_sx;

    cpu16_decode u_dec (
        .op  (st_q.ir[15:12]),
        .fn  (st_q.ir[3:0]),
        .ctl (ctl_x)
    );

    cpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (ra),
        .rb  (rb),
        .rda (rda),
        .rdb (rdb),
        .we  (rf_we),
        .wa  (st_q.ir[11:8]),
        .wd  (rf_wd)
    );

    cpu16_alu #(.W(XLEN)) u_alu (
        .a  (rda),
        .b  (alu_b),
        .op (ctl_x.alu_op),
        .y  (alu_y),
        .c  (alu_c),
        .v  (alu_v)
    );

    always_comb begin
        st_d      = st_q;
        next_pc   = pc_inc;
        rf_we     = 1'b0;
        rf_wd     = ctl_x.wb_mem ? mem_rdata : alu_y;
        mem_addr  = st_q.pc;
        mem_wdata = rda;
        mem_we    = 1'b0;
        br_take   = ctl_x.is_branch && cond_met(st_q.ir[11:8], st_q.flags);

        if (in_exec) begin
            if (ctl_x.is_jump) begin
                next_pc = rdb;
            end else if (br_take) begin
                next_pc = br_tgt;
            end
            rf_we = ctl_x.reg_we;
            case (ctl_x.flag_mode)
                FL_ALL: begin
                    st_d.flags.c = alu_c;
                    st_d.flags.v = alu_v;
                    st_d.flags.z = (alu_y == '0);
                    st_d.flags.n = alu_y[XLEN-1];
                end
                FL_ZN: begin
                    st_d.flags.z = (alu_y == '0);
                    st_d.flags.n = alu_y[XLEN-1];
                end
                default: ;
            endcase
            st_d.pc    = next_pc;
            st_d.phase = PH_FETCH;
            mem_addr   = next_pc;
        end else begin
            st_d.ir    = mem_rdata;
            st_d.phase = PH_EXEC;
            if (is_mem_op(mem_rdata[15:12], mem_rdata[3:0])) begin
                mem_addr = rdb;
            end
            mem_we = is_store_op(mem_rdata[15:12], mem_rdata[3:0]);
        end

        if (rst) begin
            mem_addr = '0;
            mem_we   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_FETCH, pc: '0, ir: '0, flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cpu16_chk.sv
module cpu16_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_exec,
    input logic        rf_we,
    input logic        mem_we,
    input logic [15:0] pc,
    input logic [15:0] mem_addr
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == 16'h0000) && !in_exec);

    a_r1_no_write_in_reset: assert property (@(posedge clk)
        rst |-> !mem_we && (mem_addr == 16'h0000));

    a_r2_fetch_to_exec: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> in_exec);

    a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (rst)
        in_exec |=> !in_exec);

    a_r2_pc_held_in_fetch: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(pc));

    a_r2_exec_addr_is_next_pc: assert property (@(posedge clk) disable iff (rst)
        in_exec |=> (pc == $past(mem_addr)));

    a_r10_store_only_in_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !in_exec);

    a_r11_rf_write_only_in_exec: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> in_exec);

endmodule

bind cpu16_core cpu16_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_exec  (in_exec),
    .rf_we    (rf_we),
    .mem_we   (mem_we),
    .pc       (st_q.pc),
    .mem_addr (mem_addr)
);

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;

    cpu16_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always #2 clk = ~clk;

    // memory model: program image plus written words, one cycle read latency
    logic [15:0] img  [256];
    logic [15:0] ram  [256];
    logic        seen [256];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) seen[i] <= 1'b0;
        end else if (mem_we) begin
            ram[mem_addr[7:0]]  <= mem_wdata;
            seen[mem_addr[7:0]] <= 1'b1;
        end
        mem_rdata <= seen[mem_addr[7:0]] ? ram[mem_addr[7:0]] : img[mem_addr[7:0]];
    end

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    int          pa = 0;
    int          cyc = 0;
    int          n_exp = 0;
    int          wr_cyc[$];
    logic [15:0] wptr = 16'h00C0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exv);
        end
    endtask

    // scoreboard monitor: every store is compared with the next expected item
    always @(negedge clk) begin : monitor
        exp_t e;
        if (!rst && mem_we) begin
            wr_cyc.push_back(cyc);
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected store", mem_addr, 16'h0000);
            end else begin
                e = sb.pop_front();
                check(mem_addr == e.a, {e.tag, " address"}, mem_addr, e.a);
                check(mem_wdata == e.d, e.tag, mem_wdata, e.d);
            end
        end
    end

    task automatic put(input logic [15:0] w);
        img[pa] = w;
        pa++;
    endtask

    task automatic ri(input logic [3:0] op, input logic [3:0] rd, input logic [7:0] imm);
        put({op, rd, imm});
    endtask

    task automatic rr(input logic [3:0] op, input logic [3:0] rd, input logic [3:0] rs);
        put({op, rd, rs, 4'h0});
    endtask

    task automatic misc(input logic [3:0] rd, input logic [3:0] rs, input logic [3:0] fn);
        put({4'h6, rd, rs, fn});
    endtask

    task automatic br(input logic [3:0] cc, input logic [7:0] disp);
        put({4'h7, cc, disp});
    endtask

    // driver side: emit a store of rd and push the expected item
    task automatic st(input logic [3:0] rd, input logic [15:0] exv, input string tag);
        sb.push_back('{a: wptr, d: exv, tag: tag});
        misc(rd, 4'd15, 4'h4);
        ri(4'h8, 4'd15, 8'h01);
        wptr = wptr + 16'h1;
    endtask

    initial begin : main
        int p;
        int n;
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
        img[8'hB0] = 16'hBEEF;

        ri(4'hE, 4'd15, 8'hC0);            // r15 = FFC0
        ri(4'hF, 4'd15, 8'h00);            // r15 = 00C0 (R5)
        ri(4'hE, 4'd1, 8'h7F);   st(4'd1, 16'h007F, "R4 MOVI positive");
        ri(4'hE, 4'd2, 8'h80);   st(4'd2, 16'hFF80, "R4 MOVI sign extend");
        ri(4'hF, 4'd2, 8'h12);   st(4'd2, 16'h1280, "R5 upper byte keeps low byte");
        misc(4'd3, 4'd1, 4'h0);
        rr(4'h0, 4'd3, 4'd2);    st(4'd3, 16'h12FF, "R3 ADD");
        misc(4'd4, 4'd1, 4'h0);
        rr(4'h1, 4'd4, 4'd2);    st(4'd4, 16'hEDFF, "R3 SUB");
        ri(4'hE, 4'd5, 8'h3C);
        ri(4'hA, 4'd5, 8'h0F);   st(4'd5, 16'h000C, "R4 ANDI");
        ri(4'hB, 4'd5, 8'hF0);   st(4'd5, 16'hFFFC, "R4 ORI sign extended");
        rr(4'h4, 4'd5, 4'd1);    st(4'd5, 16'hFF83, "R3 XOR");
        rr(4'h2, 4'd5, 4'd2);    st(4'd5, 16'h1280, "R3 AND");
        rr(4'h3, 4'd5, 4'd1);    st(4'd5, 16'h12FF, "R3 OR");
        ri(4'hE, 4'd6, 8'h81);
        misc(4'd6, 4'd6, 4'h1);  st(4'd6, 16'hFF02, "R6 shift left one");
        misc(4'd6, 4'd6, 4'h2);  st(4'd6, 16'h7F81, "R6 shift right zero fill");
        misc(4'd10, 4'd1, 4'h1); st(4'd10, 16'h00FE, "R6 shift from other register");
        // compare equal, branch taken
        ri(4'hE, 4'd7, 8'h05);
        ri(4'hE, 4'd8, 8'h22);
        ri(4'hD, 4'd7, 8'h05);
        br(4'h0, 8'h01);
        ri(4'hE, 4'd8, 8'h11);
        st(4'd7, 16'h0005, "R7 CMPI writes no register");
        st(4'd8, 16'h0022, "R8 EQ taken");
        // compare unequal, branch not taken
        ri(4'hD, 4'd7, 8'h06);
        br(4'h0, 8'h01);
        ri(4'hE, 4'd8, 8'h33);
        st(4'd8, 16'h0033, "R8 EQ not taken");
        // 5 - 6: C=0, N=1, V=0
        ri(4'hD, 4'd7, 8'h06);
        br(4'h2, 8'h01);
        ri(4'hE, 4'd8, 8'h44);
        br(4'hB, 8'h01);
        ri(4'hE, 4'd8, 8'h55);
        st(4'd8, 16'h0044, "R8 CS not taken, LT taken");
        // signed overflow
        ri(4'hE, 4'd9, 8'h7F);
        ri(4'hF, 4'd9, 8'h7F);
        rr(4'h0, 4'd9, 4'd9);
        br(4'h6, 8'h01);
        ri(4'hE, 4'd8, 8'h66);
        st(4'd9, 16'hFEFE, "R7 ADD overflow result");
        st(4'd8, 16'h0044, "R7 V set by ADD");
        // logic op updates Z, keeps C from the compare
        ri(4'hD, 4'd7, 8'h05);
        ri(4'hB, 4'd5, 8'h01);
        br(4'h2, 8'h01);
        ri(4'hE, 4'd8, 8'h99);
        br(4'h1, 8'h01);
        ri(4'hE, 4'd8, 8'h98);
        st(4'd8, 16'h0044, "R7 logic op keeps C clears Z");
        // backward branch loop, three passes
        ri(4'hE, 4'd11, 8'h03);
        ri(4'hE, 4'd12, 8'h00);
        ri(4'h8, 4'd12, 8'h02);
        ri(4'h9, 4'd11, 8'h01);
        br(4'h1, 8'hFD);
        st(4'd12, 16'h0006, "R8 backward loop count");
        st(4'd11, 16'h0000, "R8 loop exit on zero");
        // register jump, rd field names r14 which must stay unchanged
        ri(4'hE, 4'd14, 8'h5A);
        p = pa;
        ri(4'hE, 4'd13, 8'(p + 4));
        ri(4'hF, 4'd13, 8'h00);
        misc(4'd14, 4'd13, 4'h5);
        ri(4'hE, 4'd8, 8'h77);
        st(4'd8, 16'h0044, "R9 jump skips next word");
        st(4'd13, 16'(p + 4), "R9 jump target register");
        st(4'd14, 16'h005A, "R9 jump writes no link register");
        // loads
        ri(4'hE, 4'd13, 8'hB0);
        ri(4'hF, 4'd13, 8'h00);
        misc(4'd14, 4'd13, 4'h3);
        st(4'd14, 16'hBEEF, "R10 load preset word R11");
        ri(4'hE, 4'd13, 8'hC0);
        ri(4'hF, 4'd13, 8'h00);
        misc(4'd14, 4'd13, 4'h3);
        st(4'd14, 16'h007F, "R10 load back stored word");
        br(4'hE, 8'hFF);                 // halt: branch to self
        n_exp = sb.size();

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_we == 1'b0, "R1 no write in reset", {15'h0, mem_we}, 16'h0000);
        check(mem_addr == 16'h0000, "R1 address zero in reset", mem_addr, 16'h0000);
        rst = 1'b0;
        #1;
        check(mem_addr == 16'h0000, "R1 first fetch at zero", mem_addr, 16'h0000);
        @(negedge clk);
        check(mem_addr == 16'h0001, "R2 execute presents next PC", mem_addr, 16'h0001);
        @(negedge clk);
        check(mem_addr == 16'h0001, "R2 fetch holds PC", mem_addr, 16'h0001);
        @(negedge clk);
        check(mem_addr == 16'h0002, "R2 second execute", mem_addr, 16'h0002);

        n = 0;
        while (sb.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (sb.size() != 0) begin
            check(1'b0, "R2 watchdog expired", 16'(sb.size()), 16'h0000);
        end
        repeat (20) @(negedge clk);
        check(wr_cyc.size() == n_exp, "R10 store count", 16'(wr_cyc.size()), 16'(n_exp));
        if (wr_cyc.size() >= 2) begin
            check(wr_cyc[1] - wr_cyc[0] == 6, "R2 three instructions take six cycles",
                  16'(wr_cyc[1] - wr_cyc[0]), 16'd6);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule